// File: doc/BRIEF.md
# DMA Channel Command and State Controller

This block is the control/status word of a single DMA channel. Software writes a command byte into one field of a 32-bit word and polls a second field of the same word to see where the channel has got to. The block decodes the command, moves a small state machine through clearing, active, draining, paused, halted and fault conditions, and reports a multi-valued state code. Clearing and draining each last a programmable number of cycles, so software has to poll until the code settles.

The block also takes three inputs from the surrounding datapath. A work-pending flag turns "ready" into "busy" while the channel is active, and it holds off the end of a drain. A fault flag moves the channel into a sticky error condition. A halt request from an external manager stops the channel regardless of what local software asked for. One output, `fetch_en`, tells the datapath whether it may start new descriptors.

Top module: `dma_chan_ctl`

## Requirements
- R1: After the synchronous reset `rd_data` reads all zeros (state code 0, idle) and `fetch_en` is low.
- R2: The readable word holds the last written command byte in bits 23:16 and the state code in bits 15:8. All other bits read zero, whatever was written to them. A write reaches the readable word two clock edges after it is sampled.
- R3: Command 9 (clear) is accepted in every state except clearing. The channel then reports code 9 for exactly QUIESCE_CYCLES consecutive reads and then reports code 0 (idle). A clear written while clearing is ignored and does not restart the interval.
- R4: Command 1 (start) is accepted only from idle (0) or paused (3). While the channel is active it reports code 2 (busy) when `work_pending` is high and code 1 (ready) when it is low, following that input with one cycle of latency.
- R5: Command 2 (pause) is accepted only while active and starts a drain. The drain reports 1 or 2 in the same way as R4 and ends after QUIESCE_CYCLES clock cycles on which `work_pending` was low. The channel then reports code 3 (paused).
- R6: `fetch_en` is high exactly while the channel is active (codes 1 or 2 outside a drain). It is low during a drain and in every other state.
- R7: Command 0 (stop) moves the channel to idle (0) from active, paused or halted.
- R8: `fault_in` moves the channel to code 5 (fault) from active, draining or paused. Only a clear leaves the fault state, and `fault_in` is ignored while idle, clearing or halted.
- R9: `mgr_halt` moves the channel to code 4 (halted) from active, draining or paused. Only a clear or a stop leaves the halted state, and `fault_in` takes priority over `mgr_halt` in the same cycle.
- R10: A command that is not valid in the current state, or any byte other than 0, 1, 2 or 9, leaves the state unchanged. The byte is still recorded in the command field.
- R11: A clear command takes priority over `fault_in` and `mgr_halt` arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control/status word |
| wr_data | input | 32 | Written word; only bits 23:16 (command) are used |
| work_pending | input | 1 | Datapath has a transaction in flight |
| fault_in | input | 1 | Datapath error indication |
| mgr_halt | input | 1 | External manager halt request |
| rd_data | output | 32 | Registered control/status word |
| fetch_en | output | 1 | Registered permission to start new descriptors |

## Verification
The bench builds the block with QUIESCE_CYCLES set to 3. With that value the clearing and draining intervals are short enough to sample on their last cycle and on the cycle the final code appears. It also lets a command land in the middle of a clear and be shown to have no late effect. Holding `work_pending` high through a drain shows that the drain count advances only on idle cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int WORD_W  = 32;
  localparam int FIELD_W = 8;
  localparam int OP_LSB  = 16;
  localparam int ST_LSB  = 8;

  typedef enum logic [FIELD_W-1:0] {
    OP_STOP  = 8'd0,
    OP_START = 8'd1,
    OP_PAUSE = 8'd2,
    OP_CLEAR = 8'd9
  } op_code_e;

  typedef enum logic [FIELD_W-1:0] {
    SC_IDLE   = 8'd0,
    SC_READY  = 8'd1,
    SC_BUSY   = 8'd2,
    SC_PAUSED = 8'd3,
    SC_HALTED = 8'd4,
    SC_FAULT  = 8'd5,
    SC_CLEAR  = 8'd9
  } st_code_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_ACTIVE,
    F_DRAIN,
    F_PAUSED,
    F_HALTED,
    F_FAULT,
    F_CLEAR
  } fsm_e;

  typedef struct packed {
    logic stop;
    logic start;
    logic pause;
    logic clear;
  } op_req_t;

  function automatic logic [FIELD_W-1:0] state_code(input fsm_e s, input logic busy);
    case (s)
      F_IDLE:   state_code = SC_IDLE;
      F_ACTIVE,
      F_DRAIN:  state_code = busy ? SC_BUSY : SC_READY;
      F_PAUSED: state_code = SC_PAUSED;
      F_HALTED: state_code = SC_HALTED;
      F_FAULT:  state_code = SC_FAULT;
      default:  state_code = SC_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/dma_op_decode.sv
module dma_op_decode
  import dma_chan_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output op_req_t             req,
  output logic [FIELD_W-1:0]  op_field
);

  logic [FIELD_W-1:0] op_byte;
  assign op_byte = wr_data[OP_LSB +: FIELD_W];

  // Unknown codes produce no request at all.
  always_comb begin
    req = '0;
    if (wr_en) begin
      case (op_byte)
        OP_STOP:  req.stop  = 1'b1;
        OP_START: req.start = 1'b1;
        OP_PAUSE: req.pause = 1'b1;
        OP_CLEAR: req.clear = 1'b1;
        default:  req = '0;
      endcase
    end
  end

  // The command field keeps whatever byte was last written.
  always_ff @(posedge clk) begin
    if (rst)        op_field <= '0;
    else if (wr_en) op_field <= op_byte;
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[WORD_W-1:OP_LSB+FIELD_W], wr_data[OP_LSB-1:0]};

endmodule

// File: rtl/dma_quiesce_timer.sv
module dma_quiesce_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic advance,
  output logic expired
);

  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (load)                  cnt <= RELOAD;
    else if (advance && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  op_req_t req,
  input  logic    work_pending,
  input  logic    fault_in,
  input  logic    mgr_halt,
  input  logic    expired,
  output fsm_e    state,
  output logic    tmr_load,
  output logic    tmr_adv
);

  fsm_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      F_IDLE: begin
        if (req.clear)      nxt = F_CLEAR;
        else if (req.start) nxt = F_ACTIVE;
      end
      F_ACTIVE: begin
        if (req.clear)      nxt = F_CLEAR;
        else if (fault_in)  nxt = F_FAULT;
        else if (mgr_halt)  nxt = F_HALTED;
        else if (req.pause) nxt = F_DRAIN;
        else if (req.stop)  nxt = F_IDLE;
      end
      F_DRAIN: begin
        if (req.clear)                     nxt = F_CLEAR;
        else if (fault_in)                 nxt = F_FAULT;
        else if (mgr_halt)                 nxt = F_HALTED;
        else if (expired && !work_pending) nxt = F_PAUSED;
      end
      F_PAUSED: begin
        if (req.clear)      nxt = F_CLEAR;
        else if (fault_in)  nxt = F_FAULT;
        else if (mgr_halt)  nxt = F_HALTED;
        else if (req.start) nxt = F_ACTIVE;
        else if (req.stop)  nxt = F_IDLE;
      end
      F_HALTED: begin
        if (req.clear)      nxt = F_CLEAR;
        else if (req.stop)  nxt = F_IDLE;
      end
      F_FAULT: begin
        if (req.clear)      nxt = F_CLEAR;
      end
      default: begin
        if (expired)        nxt = F_IDLE;
      end
    endcase
  end

  assign tmr_load = (nxt == F_CLEAR && state != F_CLEAR) ||
                    (nxt == F_DRAIN && state != F_DRAIN);
  assign tmr_adv  = (state == F_CLEAR) || (state == F_DRAIN && !work_pending);

  always_ff @(posedge clk) begin
    if (rst) state <= F_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned QUIESCE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              work_pending,
  input  logic              fault_in,
  input  logic              mgr_halt,
  output logic [31:0]       rd_data,
  output logic              fetch_en
);

  op_req_t            req;
  logic [FIELD_W-1:0] op_field;
  fsm_e               state;
  logic               tmr_load, tmr_adv, expired;

  dma_op_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .req      (req),
    .op_field (op_field)
  );

  dma_quiesce_timer #(.CYCLES(QUIESCE_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .advance (tmr_adv),
    .expired (expired)
  );

  dma_chan_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .work_pending (work_pending),
    .fault_in     (fault_in),
    .mgr_halt     (mgr_halt),
    .expired      (expired),
    .state        (state),
    .tmr_load     (tmr_load),
    .tmr_adv      (tmr_adv)
  );

  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    word_nxt = '0;
    word_nxt[OP_LSB +: FIELD_W] = op_field;
    word_nxt[ST_LSB +: FIELD_W] = state_code(state, work_pending);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      fetch_en <= 1'b0;
    end else begin
      rd_data  <= word_nxt;
      fetch_en <= (state == F_ACTIVE);
    end
  end

endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] st,
  input logic       fetch_en
);

  // R3: clearing only ever ends in idle
  a_r3_clear_exit: assert property (@(posedge clk) disable iff (rst)
    (st == 8'd9) |=> (st == 8'd9 || st == 8'd0));

  // R5: paused is only entered from an active code
  a_r5_pause_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(st == 8'd3) |-> ($past(st) == 8'd1 || $past(st) == 8'd2));

  // R6: descriptor starts are allowed only in an active code
  a_r6_fetch_active: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> (st == 8'd1 || st == 8'd2));

  // R8: fault is left only through clearing
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (st == 8'd5) |=> (st == 8'd5 || st == 8'd9));

  // R9: halted is left only through clearing or stop
  a_r9_halt_exit: assert property (@(posedge clk) disable iff (rst)
    (st == 8'd4) |=> (st == 8'd4 || st == 8'd9 || st == 8'd0));

  // R10: the state field never carries an unlisted code
  a_r10_legal_code: assert property (@(posedge clk) disable iff (rst)
    (st <= 8'd5) || (st == 8'd9));

endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .st       (rd_data[15:8]),
  .fetch_en (fetch_en)
);

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

  localparam int Q = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        work_pending, fault_in, mgr_halt;
  logic [31:0] rd_data;
  logic        fetch_en;

  always #4 clk = ~clk;

  dma_chan_ctl #(.QUIESCE_CYCLES(Q)) u_dma_chan_ctl (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .work_pending (work_pending),
    .fault_in     (fault_in),
    .mgr_halt     (mgr_halt),
    .rd_data      (rd_data),
    .fetch_en     (fetch_en)
  );

  typedef struct {
    logic [31:0] rd;
    logic        fe;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] cur_op = 8'h00;

  function automatic logic [31:0] word(input logic [7:0] op, input logic [7:0] st);
    return {8'h00, op, st, 8'h00};
  endfunction

  task automatic check_st(input logic [7:0] st, input logic fe, input string tag);
    exp_t e;
    e.rd  = word(cur_op, st);
    e.fe  = fe;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares just after each falling edge, away from the active edge.
  always @(negedge clk) begin
    #1;
    while (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (rd_data !== e.rd || fetch_en !== e.fe) begin
        n_fail++;
        $display("FAIL %s: rd_data=%h fetch_en=%b expected rd_data=%h fetch_en=%b",
                 e.tag, rd_data, fetch_en, e.rd, e.fe);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmd(input logic [7:0] op, input logic f = 1'b0, input logic h = 1'b0);
    wr_en    = 1'b1;
    wr_data  = {8'hA5, op, 8'hC3, 8'h7E};
    fault_in = f;
    mgr_halt = h;
    cur_op   = op;
    @(negedge clk);
    wr_en    = 1'b0;
    wr_data  = '0;
    fault_in = 1'b0;
    mgr_halt = 1'b0;
  endtask

  task automatic pulse(input logic f, input logic h);
    fault_in = f;
    mgr_halt = h;
    @(negedge clk);
    fault_in = 1'b0;
    mgr_halt = 1'b0;
  endtask

  task automatic clear_seq(input string tag);
    write_cmd(8'd9);
    step(1);     check_st(8'd9, 1'b0, {tag, " R3 first clearing read"});
    step(Q - 1); check_st(8'd9, 1'b0, {tag, " R3 last clearing read"});
    step(1);     check_st(8'd0, 1'b0, {tag, " R3 idle after clearing"});
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    work_pending = 1'b0; fault_in = 1'b0; mgr_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(1); check_st(8'd0, 1'b0, "R1 reset state");

    // start, busy tracking, field layout
    write_cmd(8'd1); step(1); check_st(8'd1, 1'b1, "R2 R4 R6 start from idle, padding bits read zero");
    work_pending = 1'b1; step(1); check_st(8'd2, 1'b1, "R4 busy while work pending");
    work_pending = 1'b0; step(1); check_st(8'd1, 1'b1, "R4 ready after work drops");

    // drain held by pending work
    work_pending = 1'b1;
    write_cmd(8'd2); step(1); check_st(8'd2, 1'b0, "R5 R6 draining with work pending");
    step(5); check_st(8'd2, 1'b0, "R5 drain does not advance while busy");
    work_pending = 1'b0;
    step(Q); check_st(8'd1, 1'b0, "R5 last drain cycle");
    step(1); check_st(8'd3, 1'b0, "R5 paused after idle cycles");

    // ignored commands
    write_cmd(8'd2);   step(1); check_st(8'd3, 1'b0, "R10 pause ignored while paused");
    write_cmd(8'h07);  step(1); check_st(8'd3, 1'b0, "R10 unknown code 0x07 ignored");
    write_cmd(8'hFF);  step(1); check_st(8'd3, 1'b0, "R10 unknown code 0xFF ignored");
    write_cmd(8'd1);   step(1); check_st(8'd1, 1'b1, "R4 start from paused");

    // clear beats fault/halt; start during clearing ignored
    write_cmd(8'd9, 1'b1, 1'b1);
    step(1); check_st(8'd9, 1'b0, "R11 clear wins over fault and halt");
    write_cmd(8'd1);
    step(1); check_st(8'd9, 1'b0, "R3 last clearing read with start pending");
    step(1); check_st(8'd0, 1'b0, "R3 R10 idle after clearing, start ignored");
    step(2); check_st(8'd0, 1'b0, "R10 start during clearing has no late effect");

    // inputs ignored in idle
    pulse(1'b1, 1'b0); step(1); check_st(8'd0, 1'b0, "R8 fault ignored while idle");
    pulse(1'b0, 1'b1); step(1); check_st(8'd0, 1'b0, "R9 halt ignored while idle");
    write_cmd(8'd2);   step(1); check_st(8'd0, 1'b0, "R10 pause ignored while idle");
    write_cmd(8'd9);   write_cmd(8'd9);
    step(Q - 1); check_st(8'd9, 1'b0, "R3 second clear does not restart interval");
    step(1);     check_st(8'd0, 1'b0, "R3 idle on original schedule");

    // fault path
    write_cmd(8'd1); step(1); check_st(8'd1, 1'b1, "R4 start");
    pulse(1'b1, 1'b0); step(1); check_st(8'd5, 1'b0, "R8 fault from active");
    write_cmd(8'd1); step(1); check_st(8'd5, 1'b0, "R8 start ignored in fault");
    write_cmd(8'd0); step(1); check_st(8'd5, 1'b0, "R8 stop ignored in fault");
    clear_seq("R8 clear leaves fault");

    // halt path
    work_pending = 1'b1;
    write_cmd(8'd1); step(1); check_st(8'd2, 1'b1, "R4 start straight into busy");
    pulse(1'b0, 1'b1); step(1); check_st(8'd4, 1'b0, "R9 halt from active");
    pulse(1'b1, 1'b0); step(1); check_st(8'd4, 1'b0, "R8 fault ignored while halted");
    write_cmd(8'd1); step(1); check_st(8'd4, 1'b0, "R9 start ignored while halted");
    work_pending = 1'b0;
    write_cmd(8'd0); step(1); check_st(8'd0, 1'b0, "R7 R9 stop leaves halted");

    // fault priority over halt
    write_cmd(8'd1); step(1); check_st(8'd1, 1'b1, "R4 start");
    pulse(1'b1, 1'b1); step(1); check_st(8'd5, 1'b0, "R9 fault wins over halt");
    clear_seq("R8");

    // stop from active, drain without work, stop from paused
    write_cmd(8'd1); step(1);
    write_cmd(8'd0); step(1); check_st(8'd0, 1'b0, "R7 stop from active");
    write_cmd(8'd1); step(1);
    write_cmd(8'd2);
    step(Q); check_st(8'd1, 1'b0, "R5 last idle drain cycle");
    step(1); check_st(8'd3, 1'b0, "R5 paused after idle drain");
    write_cmd(8'd0); step(1); check_st(8'd0, 1'b0, "R7 stop from paused");

    // halt from paused
    write_cmd(8'd1); step(1);
    write_cmd(8'd2); step(Q + 1); check_st(8'd3, 1'b0, "R5 paused");
    pulse(1'b0, 1'b1); step(1); check_st(8'd4, 1'b0, "R9 halt from paused");
    clear_seq("R9 clear leaves halted");

    // fault aborts a drain
    work_pending = 1'b1;
    write_cmd(8'd1); step(1);
    write_cmd(8'd2); step(1); check_st(8'd2, 1'b0, "R5 draining");
    pulse(1'b1, 1'b0); step(1); check_st(8'd5, 1'b0, "R8 fault aborts drain");
    work_pending = 1'b0;
    clear_seq("R8");

    step(2);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1-related run control): actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule